// File: doc/BRIEF.md
# Way-Predicted Two-Way Cache Lookup

This block is the lookup path of a small two-way set-associative cache. Each set holds a one-bit guess of which way will hit next. When a request arrives, the guessed way's data is steered to the response before its tag comparison settles, and only that one tag is compared. If that single compare matches, the access finishes in one cycle. If it does not match, the other way of the same set is compared in the following cycle.

When neither way holds the line, the block raises a refill request and waits for the word to arrive. It writes the word into the way that was not guessed. After a second-cycle hit or a refill, the set's guess is moved to the way that supplied the data. Every response carries a class code, so the caller can tell the fast path, the way-miss path and a true miss apart. One request is in flight at a time.

The default configuration has 32 sets, 32-bit words and one-word lines. Addresses are word addresses: the low five bits select the set and the rest form the tag.

Top module: `wp_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and fill_req is 0. Every line is invalid and every set's guess is way 0.
- R2: If the guessed way holds the requested tag, rsp_valid is 1 in the cycle after acceptance, with rsp_class = 2'b01 and the stored word on rsp_data.
- R3: If the guessed way misses and the other way holds the tag, rsp_valid is 1 two cycles after acceptance, with rsp_class = 2'b10 and the stored word. In the cycle between acceptance and this response, rsp_valid is 0 and req_ready is 0.
- R4: After a way-miss hit, the next access to the same address is a fast hit (rsp_class = 2'b01).
- R5: If neither way holds the tag, fill_req rises two cycles after acceptance with fill_addr equal to the request address. Both stay unchanged until a cycle in which fill_valid is 1.
- R6: A cycle with fill_req and fill_valid both 1 writes fill_data into the way that was not guessed. The next cycle gives rsp_valid with rsp_class = 2'b11 and rsp_data = fill_data. The set's guess then names the filled way, so the next access to that address is a fast hit.
- R7: While req_ready is 0, rsp_valid stays 0 except for the single response cycle that ends the access. Requests presented while busy are ignored: they produce no response, and req_ready is 1 in the cycle after the response.
- R8: A refill never replaces the guessed way, so the line that was guessed survives a refill of the other line in its set.
- R9: fill_valid while no refill is pending has no effect: it gives no response and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_addr | input | AW | Word address of the request |
| req_ready | output | 1 | Block idle; a request is taken at this edge |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | DW | Word returned |
| rsp_class | output | 2 | 01 fast hit, 10 way-miss hit, 11 refilled miss |
| fill_req | output | 1 | Refill wanted |
| fill_addr | output | AW | Address to refill |
| fill_valid | input | 1 | Refill word present |
| fill_data | input | DW | Refill word |

## Verification
The embedded assertions check the timing of every access on every cycle:
- an accepted request either responds on the fast path at once or takes the block busy;
- a way-miss response only ever follows a cycle spent in the second compare;
- a pending refill holds its address;
- a delivered refill word becomes a miss-class response one cycle later.

Other behaviours depend on which way holds which line. Only the bench's scenarios can show these:
- the guess moves to the way that hit;
- the victim is the way that was not guessed;
- the surviving line stays intact;
- stray refill words leave stored data alone.

The bench shows them by running the same nine-access pattern through every set.

// File: rtl/wp_cache.sv
module wp_cache #(
  parameter int SETS = 32,
  parameter int DW   = 32,
  parameter int AW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [1:0]    rsp_class,
  output logic          fill_req,
  output logic [AW-1:0] fill_addr,
  input  logic          fill_valid,
  input  logic [DW-1:0] fill_data
);
  localparam int IW = $clog2(SETS);
  localparam int TW = AW - IW;
  localparam logic [1:0] C_FAST = 2'b01, C_WAY = 2'b10, C_MISS = 2'b11;

  typedef enum logic [1:0] {IDLE, PROBE2, REFILL} st_t;
  st_t state;

  logic [TW-1:0]   tags [2][SETS];
  logic [DW-1:0]   dat  [2][SETS];
  logic [SETS-1:0] vld  [2];
  logic [SETS-1:0] pred;
  logic [AW-1:0]   cur_addr;

  logic [IW-1:0] in_idx, cur_idx;
  logic [TW-1:0] in_tag, cur_tag;
  logic pw, alt, fast_hit, alt_hit, accept;

  assign in_idx  = req_addr[IW-1:0];
  assign in_tag  = req_addr[AW-1:IW];
  assign cur_idx = cur_addr[IW-1:0];
  assign cur_tag = cur_addr[AW-1:IW];

  // Early way select: one compare, data mux already steered by the guess
  assign pw       = pred[in_idx];
  assign fast_hit = vld[pw][in_idx] && (tags[pw][in_idx] == in_tag);

  // Second-cycle probe of the other way
  assign alt      = ~pred[cur_idx];
  assign alt_hit  = vld[alt][cur_idx] && (tags[alt][cur_idx] == cur_tag);

  assign req_ready = (state == IDLE);
  assign accept    = req_valid && req_ready;
  assign fill_req  = (state == REFILL);
  assign fill_addr = cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= IDLE;
      cur_addr  <= '0;
      pred      <= '0;
      vld[0]    <= '0;
      vld[1]    <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_class <= 2'b00;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        IDLE: if (accept) begin
          cur_addr <= req_addr;
          if (fast_hit) begin
            rsp_valid <= 1'b1;
            rsp_data  <= dat[pw][in_idx];
            rsp_class <= C_FAST;
          end else begin
            state <= PROBE2;
          end
        end
        PROBE2: if (alt_hit) begin
          rsp_valid     <= 1'b1;
          rsp_data      <= dat[alt][cur_idx];
          rsp_class     <= C_WAY;
          pred[cur_idx] <= alt;
          state         <= IDLE;
        end else begin
          state <= REFILL;
        end
        REFILL: if (fill_valid) begin
          vld[alt][cur_idx] <= 1'b1;
          pred[cur_idx]     <= alt;
          rsp_valid         <= 1'b1;
          rsp_data          <= fill_data;
          rsp_class         <= C_MISS;
          state             <= IDLE;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == REFILL && fill_valid) begin
      tags[alt][cur_idx] <= cur_tag;
      dat[alt][cur_idx]  <= fill_data;
    end
  end

  // R2
  fast_or_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_valid && rsp_class == C_FAST) || (!rsp_valid && !req_ready));

  // R3
  way_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_class == C_WAY) |-> ($past(!req_ready) && !$past(fill_req)));

  // R5
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

  // R6
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && fill_valid) |=> (rsp_valid && rsp_class == C_MISS && rsp_data == $past(fill_data)));

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> !rsp_valid);

  // R2
  class_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_class != 2'b00));
endmodule

// File: tb/wp_cache_test.sv
module wp_cache_test;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, fill_valid = 0;
  logic [31:0] req_addr = '0, fill_data = '0;
  logic        req_ready, rsp_valid, fill_req;
  logic [31:0] rsp_data, fill_addr;
  logic [1:0]  rsp_class;
  int checks = 0, fails = 0;
  bit done = 0;

  localparam logic [1:0] FAST = 2'b01, WAY = 2'b10, MISS = 2'b11;

  always #2 clk = ~clk;

  wp_cache uut (.clk, .rst_n, .req_valid, .req_addr, .req_ready, .rsp_valid,
                .rsp_data, .rsp_class, .fill_req, .fill_addr, .fill_valid, .fill_data);

  function automatic logic [31:0] fdat(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] mk(int tag, int s);
    return (32'(tag) << 5) | 32'(s);
  endfunction

  task automatic chk(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic access(logic [31:0] a, logic [1:0] exp, string rq, int stall, bit junk);
    @(negedge clk); req_valid = 1; req_addr = a;
    @(negedge clk); req_valid = 0;
    if (exp == FAST) begin
      chk(rsp_valid && rsp_class == FAST, rq, {rsp_valid, rsp_class}, {1'b1, FAST});
      chk(rsp_data == fdat(a), rq, rsp_data, fdat(a));
      return;
    end
    chk(!rsp_valid && !req_ready, "R3", {rsp_valid, req_ready}, 2'b00);
    @(negedge clk);
    if (exp == WAY) begin
      chk(rsp_valid && rsp_class == WAY, rq, {rsp_valid, rsp_class}, {1'b1, WAY});
      chk(rsp_data == fdat(a), rq, rsp_data, fdat(a));
      return;
    end
    chk(fill_req && fill_addr == a, "R5", {fill_req, fill_addr}, {1'b1, a});
    for (int k = 0; k < stall; k++) begin
      if (junk) begin req_valid = 1; req_addr = a ^ 32'hFFFF_FFE0; end
      @(negedge clk);
      chk(fill_req && fill_addr == a && !rsp_valid, "R5", {fill_req, fill_addr}, {1'b1, a});
    end
    req_valid = 0; fill_valid = 1; fill_data = fdat(a);
    @(negedge clk); fill_valid = 0;
    chk(rsp_valid && rsp_class == MISS, rq, {rsp_valid, rsp_class}, {1'b1, MISS});
    chk(rsp_data == fdat(a), rq, rsp_data, fdat(a));
    if (junk) begin
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R7", {rsp_valid, req_ready}, 2'b01);
    end
  endtask

  task automatic stray_fill();
    @(negedge clk); fill_valid = 1; fill_data = 32'hDEAD_BEEF;
    @(negedge clk); fill_valid = 0;
    chk(!rsp_valid && req_ready && !fill_req, "R9", {rsp_valid, req_ready, fill_req}, 3'b010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !fill_req, "R1", {req_ready, rsp_valid, fill_req}, 3'b100);
    for (int s = 0; s < 32; s++) begin
      logic [31:0] a, b, c;
      a = mk(s + 1, s); b = mk(s + 100, s); c = mk(s + 200, s);
      access(a, MISS, "R1_R6", s % 3, s[0]);
      access(a, FAST, "R6", 0, 0);
      access(b, MISS, "R6", (s + 1) % 3, 0);
      stray_fill();
      access(a, WAY,  "R3_R8_R9", 0, 0);
      access(a, FAST, "R4", 0, 0);
      access(b, WAY,  "R3", 0, 0);
      access(c, MISS, "R6", 0, s[1]);
      access(b, WAY,  "R8", 0, 0);
      access(a, MISS, "R6_victim", 1, 0);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule